// File: doc/BRIEF.md
# Vector Length Control Registers

This block holds the length state that a vector-capable pipeline consults on every vector operation: the maximum vector length, the current vector length, a saved source and destination element offset, and a small bank/size configuration field. The pipeline presents one control-register access per cycle. Each access selects the maximum-length register, the current-length register or a packed state word. It is a read, a write from a 64-bit register operand or a write from a 5-bit immediate. The block answers one cycle later with the value for the destination register and an illegal-value flag.

Lengths are never zero. The immediate form and the packed form therefore store a length minus one, while the register form passes the length directly and rejects zero. Every write is clamped so that the current length never exceeds the maximum and the saved offsets never point past the current length. Only saving and restoring the offsets is modelled; nothing here advances them.

Top module: `vlen_csr_unit`

## Requirements
- R1: After reset the maximum length is XLEN (64), the current length is 1, and both offsets, the bank field and the size field are zero.
- R2: A read (accOp 0 or 3) of the maximum length (accSel 0) or the current length (accSel 1) returns the true length, not length minus one, and changes no state. A read of the packed word (accSel 2) returns max-1 in bits 5:0, current-1 in bits 11:6, source offset in 17:12, destination offset in 23:18, bank in 25:24 and size in 28:26, with all other bits zero.
- R3: A maximum-length write returns the maximum length held before the write and sets it to the smaller of the requested length and XLEN.
- R4: A current-length write sets the current length to the smaller of the requested length and the maximum length, and returns this new current length.
- R5: In the immediate form (accOp 2) the requested length for either length register is the immediate plus one.
- R6: In the register form (accOp 1) the operand is the requested length; an operand of zero for either length register raises illegalTrap, returns zero and leaves all state unchanged.
- R7: A maximum-length write that lands below the current length lowers the current length to the new maximum in the same access.
- R8: A packed-word write returns the packed word held before the write; it sets the maximum to its field plus one, then the current length to the smaller of its field plus one and the new maximum. In the immediate form the zero-extended immediate is the packed word. A packed-word write never traps.
- R9: On a packed-word write each offset saturates to the new current length minus one. The bank and size fields are stored, and bits above bit 28 are ignored.
- R10: An access presented with accValid in one cycle has its result, rdValid and illegalTrap registered at the next clock edge. Selector 3 touches nothing and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accSel | input | 2 | 0 max length, 1 current length, 2 packed word, 3 none |
| accOp | input | 2 | 0 read, 1 register write, 2 immediate write, 3 read |
| regOperand | input | 64 | Register operand for register writes |
| immOperand | input | 5 | Immediate operand for immediate writes |
| rdValue | output | 64 | Value returned for the destination register |
| rdValid | output | 1 | rdValue belongs to the access of the previous cycle |
| illegalTrap | output | 1 | The previous access carried a zero length |

## Verification
The embedded assertions watch, on every cycle, that both lengths stay inside their legal ranges and that a trapped access leaves the lengths untouched. They also check that the value returned by a length write matches the old maximum or the new current length, and that offsets follow the new current length after a packed write. Only the bench's directed scenarios can show the actual encodings: the plus-one interpretation of immediates and packed fields, the bit placement of the packed word, the ordering of the clamps across fields, and that the ignored upper bits and the empty selector really leave the state alone.

// File: rtl/vlen_csr_pkg.sv
package vlen_csr_pkg;

  typedef enum logic [1:0] {
    SEL_MVL   = 2'd0,
    SEL_VL    = 2'd1,
    SEL_STATE = 2'd2,
    SEL_NONE  = 2'd3
  } csrSel_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_WREG = 2'd1,
    OP_WIMM = 2'd2,
    OP_RSVD = 2'd3
  } csrOp_e;

  typedef enum logic [1:0] {
    RET_ZERO   = 2'd0,
    RET_MVL    = 2'd1,
    RET_NEWVL  = 2'd2,
    RET_STATE  = 2'd3
  } retSel_e;

  // Strobes from control to datapath for one access.
  typedef struct packed {
    logic    resValid;
    logic    trap;
    logic    ldMvl;
    logic    ldVl;
    logic    vlFromReq;
    logic    ldOffs;
    logic    ldCfg;
    logic    fromState;
    logic    fromImm;
    retSel_e retSel;
  } ctlStrobe_s;

endpackage

// File: rtl/vlen_csr_ctrl.sv
module vlen_csr_ctrl
  import vlen_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accValid,
  input  logic [1:0] accSel,
  input  logic [1:0] accOp,
  input  logic       opZero,
  output ctlStrobe_s str
);

  csrSel_e selQ;
  csrOp_e  opQ;
  logic    isWrite;

  assign selQ    = csrSel_e'(accSel);
  assign opQ     = csrOp_e'(accOp);
  assign isWrite = (opQ == OP_WREG) || (opQ == OP_WIMM);

  always_comb begin
    str = '0;
    str.retSel = RET_ZERO;
    if (accValid) begin
      str.resValid = 1'b1;
      unique case (selQ)
        SEL_MVL: begin
          str.retSel = RET_MVL;
          if (isWrite) begin
            if (opQ == OP_WREG && opZero) begin
              str.trap   = 1'b1;
              str.retSel = RET_ZERO;
            end else begin
              str.ldMvl   = 1'b1;
              str.ldVl    = 1'b1;   // shrink current length if needed
              str.fromImm = (opQ == OP_WIMM);
            end
          end
        end
        SEL_VL: begin
          str.retSel = RET_NEWVL;
          if (isWrite) begin
            if (opQ == OP_WREG && opZero) begin
              str.trap   = 1'b1;
              str.retSel = RET_ZERO;
            end else begin
              str.ldVl      = 1'b1;
              str.vlFromReq = 1'b1;
              str.fromImm   = (opQ == OP_WIMM);
            end
          end
        end
        SEL_STATE: begin
          str.retSel = RET_STATE;
          if (isWrite) begin
            str.ldMvl     = 1'b1;
            str.ldVl      = 1'b1;
            str.vlFromReq = 1'b1;
            str.ldOffs    = 1'b1;
            str.ldCfg     = 1'b1;
            str.fromState = 1'b1;
            str.fromImm   = (opQ == OP_WIMM);
          end
        end
        default: str.retSel = RET_ZERO;
      endcase
    end
  end

  // R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.trap |-> !(str.ldMvl || str.ldVl || str.ldOffs || str.ldCfg));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |-> (str == '0));

endmodule

// File: rtl/vlen_csr_dpath.sv
module vlen_csr_dpath
  import vlen_csr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int BANKW = 2,
  parameter int SIZEW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_s       str,
  input  logic [XLEN-1:0]  regOperand,
  input  logic [4:0]       immOperand,
  output logic             opZero,
  output logic [XLEN-1:0]  rdValue,
  output logic             rdValid,
  output logic             illegalTrap
);

  localparam int FIELDW    = $clog2(XLEN);
  localparam int LENW      = FIELDW + 1;
  localparam int NOFFS     = 2;
  localparam int BANK_LSB  = (2 + NOFFS) * FIELDW;
  localparam int SIZE_LSB  = BANK_LSB + BANKW;
  localparam int STATE_TOP = SIZE_LSB + SIZEW;
  localparam logic [LENW-1:0] MAXLEN = LENW'(XLEN);

  function automatic logic [LENW-1:0] minLen(input logic [LENW-1:0] a,
                                             input logic [LENW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [LENW-1:0] satLen(input logic [XLEN-1:0] v);
    return (v > XLEN'(XLEN)) ? MAXLEN : v[LENW-1:0];
  endfunction

  // Architectural state
  logic [LENW-1:0]             mvl, vl;
  logic [NOFFS-1:0][FIELDW-1:0] offQ;
  logic [BANKW-1:0]            bankQ;
  logic [SIZEW-1:0]            sizeQ;

  // Write word for the packed form
  logic [STATE_TOP-1:0] wrWord;
  logic [LENW-1:0]      reqMvl, reqVl, nextMvl, nextVl;
  logic [XLEN-1:0]      stateWord, resNext;

  assign opZero = ~|regOperand;
  assign wrWord = str.fromImm ? STATE_TOP'(immOperand) : regOperand[STATE_TOP-1:0];

  // Requested lengths: packed fields and immediates are length minus one.
  always_comb begin
    if (str.fromState) begin
      reqMvl = {1'b0, wrWord[FIELDW-1:0]} + 1'b1;
      reqVl  = {1'b0, wrWord[2*FIELDW-1:FIELDW]} + 1'b1;
    end else if (str.fromImm) begin
      reqMvl = LENW'(immOperand) + 1'b1;
      reqVl  = LENW'(immOperand) + 1'b1;
    end else begin
      reqMvl = satLen(regOperand);
      reqVl  = satLen(regOperand);
    end
  end

  // Resolution order: maximum first, then current against the new maximum.
  assign nextMvl = str.ldMvl ? minLen(reqMvl, MAXLEN) : mvl;
  assign nextVl  = str.ldVl  ? minLen(str.vlFromReq ? reqVl : vl, nextMvl) : vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvl <= MAXLEN;
      vl  <= LENW'(1);
    end else begin
      mvl <= nextMvl;
      vl  <= nextVl;
    end
  end

  // Offsets saturate against the newly resolved current length.
  for (genvar i = 0; i < NOFFS; i++) begin : g_off
    localparam int LSB = (2 + i) * FIELDW;
    logic [FIELDW-1:0] fieldVal, clampVal, q;
    assign fieldVal = wrWord[LSB +: FIELDW];
    assign clampVal = ({1'b0, fieldVal} >= nextVl) ? FIELDW'(nextVl - 1'b1) : fieldVal;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (str.ldOffs) q <= clampVal;
    end
    assign offQ[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankQ <= '0;
      sizeQ <= '0;
    end else if (str.ldCfg) begin
      bankQ <= wrWord[BANK_LSB +: BANKW];
      sizeQ <= wrWord[SIZE_LSB +: SIZEW];
    end
  end

  // Packed view of the current state.
  always_comb begin
    stateWord = '0;
    stateWord[FIELDW-1:0]        = FIELDW'(mvl - 1'b1);
    stateWord[2*FIELDW-1:FIELDW] = FIELDW'(vl - 1'b1);
    for (int k = 0; k < NOFFS; k++)
      stateWord[(2 + k) * FIELDW +: FIELDW] = offQ[k];
    stateWord[BANK_LSB +: BANKW] = bankQ;
    stateWord[SIZE_LSB +: SIZEW] = sizeQ;
  end

  always_comb begin
    unique case (str.retSel)
      RET_MVL:   resNext = XLEN'(mvl);
      RET_NEWVL: resNext = XLEN'(nextVl);
      RET_STATE: resNext = stateWord;
      default:   resNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValue     <= '0;
      rdValid     <= 1'b0;
      illegalTrap <= 1'b0;
    end else begin
      rdValue     <= resNext;
      rdValid     <= str.resValid;
      illegalTrap <= str.trap;
    end
  end

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mvl >= LENW'(1)) && (mvl <= MAXLEN) && (vl >= LENW'(1)) && (vl <= mvl));

  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.trap |=> (mvl == $past(mvl)) && (vl == $past(vl)) && illegalTrap);

  // R3
  mvl_ret_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (str.ldMvl && str.retSel == RET_MVL) |=> (rdValue == XLEN'($past(mvl))));

  // R4
  vl_ret_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (str.ldVl && str.retSel == RET_NEWVL) |=> (rdValue == XLEN'(vl)));

  // R9
  offs_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.ldOffs |=> ({1'b0, offQ[0]} < vl) && ({1'b0, offQ[1]} < vl));

endmodule

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit
  import vlen_csr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int BANKW = 2,
  parameter int SIZEW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accValid,
  input  logic [1:0]      accSel,
  input  logic [1:0]      accOp,
  input  logic [XLEN-1:0] regOperand,
  input  logic [4:0]      immOperand,
  output logic [XLEN-1:0] rdValue,
  output logic            rdValid,
  output logic            illegalTrap
);

  ctlStrobe_s str;
  logic       opZero;

  vlen_csr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accValid (accValid),
    .accSel   (accSel),
    .accOp    (accOp),
    .opZero   (opZero),
    .str      (str)
  );

  vlen_csr_dpath #(
    .XLEN  (XLEN),
    .BANKW (BANKW),
    .SIZEW (SIZEW)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .str         (str),
    .regOperand  (regOperand),
    .immOperand  (immOperand),
    .opZero      (opZero),
    .rdValue     (rdValue),
    .rdValid     (rdValid),
    .illegalTrap (illegalTrap)
  );

endmodule

// File: tb/vlen_csr_unit_test.sv
module vlen_csr_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accSel = 2'd0;
  logic [1:0]  accOp = 2'd0;
  logic [63:0] regOperand = '0;
  logic [4:0]  immOperand = '0;
  logic [63:0] rdValue;
  logic        rdValid;
  logic        illegalTrap;

  int checks = 0;
  int failures = 0;
  logic [63:0] lastRes;
  logic        lastTrap;

  always #10 clk = ~clk;   // 50 MHz

  vlen_csr_unit uut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSel(accSel),
    .accOp(accOp), .regOperand(regOperand), .immOperand(immOperand),
    .rdValue(rdValue), .rdValid(rdValid), .illegalTrap(illegalTrap)
  );

  function automatic logic [63:0] pack(input int m, input int v, input int s,
                                       input int d, input int b, input int z);
    logic [63:0] w;
    w = '0;
    w[5:0]   = 6'(m - 1);
    w[11:6]  = 6'(v - 1);
    w[17:12] = 6'(s);
    w[23:18] = 6'(d);
    w[25:24] = 2'(b);
    w[28:26] = 3'(z);
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One access: drive at a falling edge, result registered at the next rising edge.
  task automatic access(input logic [1:0] sel, input logic [1:0] op,
                        input logic [63:0] r, input logic [4:0] imm);
    @(negedge clk);
    accValid = 1'b1; accSel = sel; accOp = op; regOperand = r; immOperand = imm;
    @(negedge clk);
    accValid = 1'b0; regOperand = '0; immOperand = '0;
    lastRes  = rdValue;
    lastTrap = illegalTrap;
    checks++;
    if (rdValid !== 1'b1) begin
      failures++;
      $display("FAIL R10 rdValid actual=%0d expected=1", rdValid);
    end
  endtask

  task automatic test_reset();
    check("R10 idle", {63'd0, rdValid}, 64'd0);
    access(2'd0, 2'd0, '0, '0); check("R1 mvl", lastRes, 64'd64);
    access(2'd1, 2'd3, '0, '0); check("R1 vl", lastRes, 64'd1);
    access(2'd2, 2'd0, '0, '0); check("R1 R2 state", lastRes, pack(64, 1, 0, 0, 0, 0));
    @(negedge clk);
    check("R10 valid drops", {63'd0, rdValid}, 64'd0);
  endtask

  task automatic test_imm_mvl();
    access(2'd0, 2'd2, '0, 5'd3); check("R3 R5 ret old", lastRes, 64'd64);
    access(2'd0, 2'd0, '0, '0);   check("R5 mvl", lastRes, 64'd4);
  endtask

  task automatic test_vl_reg();
    access(2'd1, 2'd1, 64'd10, '0); check("R4 clamp ret new", lastRes, 64'd4);
    access(2'd1, 2'd1, 64'd2, '0);  check("R4 ret new", lastRes, 64'd2);
  endtask

  task automatic test_trap();
    access(2'd1, 2'd1, 64'd0, '0);
    check("R6 trap flag", {63'd0, lastTrap}, 64'd1);
    check("R6 trap value", lastRes, 64'd0);
    access(2'd1, 2'd0, '0, '0); check("R6 vl kept", lastRes, 64'd2);
    access(2'd0, 2'd1, 64'd0, '0);
    check("R6 mvl trap", {63'd0, lastTrap}, 64'd1);
    access(2'd0, 2'd0, '0, '0); check("R6 mvl kept", lastRes, 64'd4);
    check("R6 trap clears", {63'd0, lastTrap}, 64'd0);
  endtask

  task automatic test_mvl_reg();
    access(2'd0, 2'd1, 64'd100, '0); check("R3 ret old", lastRes, 64'd4);
    access(2'd0, 2'd0, '0, '0);      check("R3 sat XLEN", lastRes, 64'd64);
    access(2'd1, 2'd0, '0, '0);      check("R2 vl read", lastRes, 64'd2);
  endtask

  task automatic test_vl_imm();
    access(2'd1, 2'd2, '0, 5'd31); check("R5 vl imm", lastRes, 64'd32);
  endtask

  task automatic test_shrink();
    access(2'd0, 2'd2, '0, 5'd7); check("R3 ret", lastRes, 64'd64);
    access(2'd1, 2'd0, '0, '0);   check("R7 vl shrunk", lastRes, 64'd8);
  endtask

  task automatic test_state_write();
    logic [63:0] w;
    w = pack(10, 21, 30, 3, 2, 5) | (64'd1 << 40);
    access(2'd2, 2'd1, w, '0); check("R8 ret old", lastRes, pack(8, 8, 0, 0, 0, 0));
    check("R8 no trap", {63'd0, lastTrap}, 64'd0);
    access(2'd2, 2'd0, '0, '0); check("R8 R9 packed", lastRes, pack(10, 10, 9, 3, 2, 5));
    access(2'd1, 2'd0, '0, '0); check("R8 vl", lastRes, 64'd10);
    access(2'd0, 2'd0, '0, '0); check("R8 mvl", lastRes, 64'd10);
  endtask

  task automatic test_state_order();
    access(2'd2, 2'd1, pack(64, 1, 5, 5, 0, 0), '0);
    check("R8 ret old", lastRes, pack(10, 10, 9, 3, 2, 5));
    access(2'd2, 2'd0, '0, '0); check("R9 offs to zero", lastRes, pack(64, 1, 0, 0, 0, 0));
  endtask

  task automatic test_state_imm();
    access(2'd2, 2'd2, '0, 5'd5); check("R8 imm ret", lastRes, pack(64, 1, 0, 0, 0, 0));
    access(2'd0, 2'd0, '0, '0);   check("R8 imm mvl", lastRes, 64'd6);
    access(2'd2, 2'd1, 64'd0, '0);
    check("R8 zero no trap", {63'd0, lastTrap}, 64'd0);
    access(2'd0, 2'd0, '0, '0);   check("R8 zero mvl", lastRes, 64'd1);
  endtask

  task automatic test_none_sel();
    access(2'd3, 2'd1, 64'd5, '0); check("R10 none ret", lastRes, 64'd0);
    access(2'd0, 2'd0, '0, '0);    check("R10 none kept", lastRes, 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_imm_mvl();
    test_vl_reg();
    test_trap();
    test_mvl_reg();
    test_vl_imm();
    test_shrink();
    test_state_write();
    test_state_order();
    test_state_imm();
    test_none_sel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule